// File: doc/BRIEF.md
# Banked Interrupt Priority Mask Unit

This block holds the masking state a processor core uses to gate exception preemption. It has a one-bit general mask and a one-bit fault mask. It also has an 8-bit base-priority threshold, which is kept as two copies, one for each security state. A small register-access port reads and writes this state by select code. Every access to the threshold goes to the copy chosen by the current security state.

Besides the plain threshold write, the threshold has a raise-only alias. A write through the alias only tightens the mask: it takes effect when it would make the threshold stricter, and otherwise it is dropped.

From the masks, the current threshold copy and a group-priority mask, the block derives a masking priority. It then compares this with the priority of the active exception and outputs the smaller of the two as the current execution priority. The priority arbiter downstream uses this value to decide whether a pending exception may preempt.

Top module: `prio_mask_unit`

## Requirements
- R1: The threshold has two copies, selected by `sec_state` (0 = non-secure copy, 1 = secure copy). A write through select code 17 or 18 changes only the selected copy. A read through 17 or 18 returns only the selected copy.
- R2: A write with select code 17 stores `wr_data[7:0]` into the selected threshold copy. The upper bits are discarded.
- R3: A write with select code 18 stores `wr_data[7:0]` only in this case: the value is nonzero, and either it is numerically lower than the stored copy or the stored copy is zero. In every other case the write leaves the copy unchanged.
- R4: A read with select code 17 or with select code 18 returns the selected threshold copy, zero-extended to 32 bits.
- R5: A write with select code 16 sets the general mask to `wr_data[0]`. A write with select code 19 sets the fault mask to `wr_data[0]`. A read of either code returns that bit in bit 0.
- R6: The masking priority is chosen in this order:
  - -1 when the fault mask is set;
  - else 0 when the general mask is set;
  - else (threshold AND `grp_mask`) when the selected threshold copy is nonzero;
  - else 256.
- R7: `exec_prio` is the signed minimum of the masking priority and `act_prio`. It is registered, so it reflects the state and inputs of the previous cycle.
- R8: While `rst` is high, both threshold copies and both masks are cleared, `rd_data` is 0 and `exec_prio` is 256.
- R9: Select codes other than 16 to 19 read as zero, and writes to them change no state.
- R10: `rd_data` is registered and shows the value held before any write presented in the same cycle. A write becomes visible to a read one cycle later.
- R11: With parameter `SEC_EXT` = 0, `sec_state` is ignored and copy 0 is used for every access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 5 | Register select code |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| sec_state | input | 1 | Current security state (1 = secure) |
| grp_mask | input | 8 | Group-priority mask applied to the threshold |
| act_prio | input | 10 | Signed priority of the active exception |
| rd_data | output | 32 | Registered read data for `sel` |
| exec_prio | output | 10 | Registered signed execution priority |

## Verification
The assertions assume that `act_prio` lies between -1 and 256, the range of real exception priorities. The fault-mask property depends on this: it treats any negative result as correct. The stimulus keeps `act_prio` within that range and sweeps `grp_mask` and `sec_state` independently of the register accesses. Two instances run side by side, one with the security extension and one without. This lets each write to one bank be checked against the other bank and against the unbanked instance.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int unsigned SEL_GEN_MASK     = 16;
  localparam int unsigned SEL_THRESH       = 17;
  localparam int unsigned SEL_THRESH_RAISE = 18;
  localparam int unsigned SEL_FAULT_MASK   = 19;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_GEN,
    ACC_THR,
    ACC_RAISE,
    ACC_FAULT
  } acc_kind_e;

endpackage

// File: rtl/pmu_sel_decode.sv
module pmu_sel_decode
  import pmu_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic [SEL_W-1:0] sel,
  output acc_kind_e        kind
);

  always_comb begin
    if (sel == SEL_W'(SEL_GEN_MASK))          kind = ACC_GEN;
    else if (sel == SEL_W'(SEL_THRESH))       kind = ACC_THR;
    else if (sel == SEL_W'(SEL_THRESH_RAISE)) kind = ACC_RAISE;
    else if (sel == SEL_W'(SEL_FAULT_MASK))   kind = ACC_FAULT;
    else                                      kind = ACC_NONE;
  end

endmodule

// File: rtl/pmu_threshold_bank.sv
module pmu_threshold_bank #(
  parameter int PRIO_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  bank_idx,
  input  logic              wr_plain,
  input  logic              wr_raise,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PRIO_W-1:0] cur_thr
);

  logic [PRIO_W-1:0] thr_q [NUM_BANKS];
  logic [PRIO_W-1:0] new_val;
  logic              raise_ok;
  logic              do_wr;

  assign cur_thr  = thr_q[bank_idx];
  assign new_val  = wr_data[PRIO_W-1:0];
  assign raise_ok = (new_val != '0) && ((new_val < cur_thr) || (cur_thr == '0));
  assign do_wr    = wr_plain || (wr_raise && raise_ok);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst) begin
        thr_q[k] <= '0;
      end else if (do_wr && (bank_idx == IDX_W'(k))) begin
        thr_q[k] <= new_val;
      end
    end

    // R1
    other_bank_stable_chk: assert property (@(posedge clk) disable iff (rst)
      ((wr_plain || wr_raise) && (bank_idx != IDX_W'(k))) |=> $stable(thr_q[k]));

    // R3
    raise_never_loosens_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_raise && !wr_plain && (bank_idx == IDX_W'(k)) && (thr_q[k] != '0))
        |=> (thr_q[k] <= $past(thr_q[k])));
  end

endmodule

// File: rtl/pmu_mask_bits.sv
module pmu_mask_bits (
  input  logic clk,
  input  logic rst,
  input  logic wr_gen,
  input  logic wr_fault,
  input  logic wr_bit,
  output logic gen_mask,
  output logic fault_mask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_mask   <= 1'b0;
      fault_mask <= 1'b0;
    end else begin
      if (wr_gen)   gen_mask   <= wr_bit;
      if (wr_fault) fault_mask <= wr_bit;
    end
  end

  // R5
  gen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_gen |=> $stable(gen_mask));

  // R5
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_fault |=> $stable(fault_mask));

endmodule

// File: rtl/pmu_prio_resolve.sv
module pmu_prio_resolve #(
  parameter int PRIO_W  = 8,
  localparam int EXEC_W = PRIO_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fault_mask,
  input  logic                     gen_mask,
  input  logic [PRIO_W-1:0]        cur_thr,
  input  logic [PRIO_W-1:0]        grp_mask,
  input  logic signed [EXEC_W-1:0] act_prio,
  output logic signed [EXEC_W-1:0] exec_prio
);

  localparam logic signed [EXEC_W-1:0] NOEXC = EXEC_W'(1 << PRIO_W);

  logic signed [EXEC_W-1:0] mask_prio;
  logic signed [EXEC_W-1:0] exec_d;

  always_comb begin
    if (fault_mask)          mask_prio = '1;
    else if (gen_mask)       mask_prio = '0;
    else if (cur_thr != '0)  mask_prio = {2'b00, cur_thr & grp_mask};
    else                     mask_prio = NOEXC;
  end

  assign exec_d = (act_prio < mask_prio) ? act_prio : mask_prio;

  always_ff @(posedge clk) begin
    if (rst) exec_prio <= NOEXC;
    else     exec_prio <= exec_d;
  end

  // R6
  fault_neg_chk: assert property (@(posedge clk) disable iff (rst)
    fault_mask |=> exec_prio[EXEC_W-1]);

  // R6
  gen_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!fault_mask && gen_mask) |=> (exec_prio <= 0));

  // R7
  exec_le_act_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (exec_prio <= $past(act_prio)));

endmodule

// File: rtl/prio_mask_unit.sv
module prio_mask_unit
  import pmu_pkg::*;
#(
  parameter int  DATA_W    = 32,
  parameter int  PRIO_W    = 8,
  parameter int  SEL_W     = 5,
  parameter int  NUM_BANKS = 2,
  parameter bit  SEC_EXT   = 1'b1,
  localparam int EXEC_W    = PRIO_W + 2,
  localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SEL_W-1:0]         sel,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     sec_state,
  input  logic [PRIO_W-1:0]        grp_mask,
  input  logic signed [EXEC_W-1:0] act_prio,
  output logic [DATA_W-1:0]        rd_data,
  output logic signed [EXEC_W-1:0] exec_prio
);

  acc_kind_e         kind;
  logic [IDX_W-1:0]  bank_idx;
  logic [PRIO_W-1:0] cur_thr;
  logic              gen_mask;
  logic              fault_mask;
  logic [DATA_W-1:0] rd_d;

  if (SEC_EXT) begin : g_sec
    assign bank_idx = IDX_W'(sec_state);
  end else begin : g_nosec
    assign bank_idx = '0;
  end

  pmu_sel_decode #(.SEL_W(SEL_W)) u_dec (
    .sel  (sel),
    .kind (kind)
  );

  pmu_threshold_bank #(
    .PRIO_W    (PRIO_W),
    .NUM_BANKS (NUM_BANKS),
    .DATA_W    (DATA_W)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .bank_idx (bank_idx),
    .wr_plain (wr_en && (kind == ACC_THR)),
    .wr_raise (wr_en && (kind == ACC_RAISE)),
    .wr_data  (wr_data),
    .cur_thr  (cur_thr)
  );

  pmu_mask_bits u_masks (
    .clk        (clk),
    .rst        (rst),
    .wr_gen     (wr_en && (kind == ACC_GEN)),
    .wr_fault   (wr_en && (kind == ACC_FAULT)),
    .wr_bit     (wr_data[0]),
    .gen_mask   (gen_mask),
    .fault_mask (fault_mask)
  );

  pmu_prio_resolve #(.PRIO_W(PRIO_W)) u_resolve (
    .clk        (clk),
    .rst        (rst),
    .fault_mask (fault_mask),
    .gen_mask   (gen_mask),
    .cur_thr    (cur_thr),
    .grp_mask   (grp_mask),
    .act_prio   (act_prio),
    .exec_prio  (exec_prio)
  );

  always_comb begin
    unique case (kind)
      ACC_GEN:           rd_d = DATA_W'(gen_mask);
      ACC_FAULT:         rd_d = DATA_W'(fault_mask);
      ACC_THR, ACC_RAISE: rd_d = DATA_W'(cur_thr);
      default:           rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end

  // R9
  unsupported_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_NONE) |=> (rd_data == '0));

  // R10
  read_shows_old_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_THR || kind == ACC_RAISE) |=> (rd_data == DATA_W'($past(cur_thr))));

endmodule

// File: tb/tb_prio_mask_unit.sv
module tb_prio_mask_unit;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] rd_s;
    logic [31:0] rd_n;
    int          ex_s;
    int          ex_n;
    string       tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [4:0]        sel = '0;
  logic              wr_en = 1'b0;
  logic [31:0]       wr_data = '0;
  logic              sec_state = 1'b0;
  logic [7:0]        grp_mask = 8'hFF;
  logic signed [9:0] act_prio = 10'sd256;
  logic [31:0]       rd_s, rd_n;
  logic signed [9:0] ex_s, ex_n;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  exp_t sb[$];

  // reference state: [bank] thresholds for secure-capable, one for non-capable
  int thr_s[2];
  int thr_n;
  int gm_s, fm_s, gm_n, fm_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_mask_unit #(.SEC_EXT(1'b1)) dut (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .sec_state(sec_state), .grp_mask(grp_mask), .act_prio(act_prio),
    .rd_data(rd_s), .exec_prio(ex_s)
  );

  prio_mask_unit #(.SEC_EXT(1'b0)) dut_nsx (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .sec_state(sec_state), .grp_mask(grp_mask), .act_prio(act_prio),
    .rd_data(rd_n), .exec_prio(ex_n)
  );

  function automatic int mask_p(int fm, int gm, int thr, int gmask);
    if (fm != 0) return -1;
    if (gm != 0) return 0;
    if (thr != 0) return thr & gmask;
    return 256;
  endfunction

  function automatic int rd_model(int s, int fm, int gm, int thr);
    case (s)
      16: return gm;
      17, 18: return thr;
      19: return fm;
      default: return 0;
    endcase
  endfunction

  function automatic int thr_next(int s, int we, int d, int thr);
    int v = d & 8'hFF;
    if (we == 0) return thr;
    if (s == 17) return v;
    if (s == 18 && v != 0 && (v < thr || thr == 0)) return v;
    return thr;
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic op(input int s, input bit we, input logic [31:0] d,
                    input bit sec, input int gmask, input int act, input string tag);
    exp_t e;
    int ms, mn;
    @(negedge clk);
    sel = 5'(s); wr_en = we; wr_data = d; sec_state = sec;
    grp_mask = 8'(gmask); act_prio = 10'(act);
    ms = mask_p(fm_s, gm_s, thr_s[sec], gmask);
    mn = mask_p(fm_n, gm_n, thr_n, gmask);
    e.rd_s = 32'(rd_model(s, fm_s, gm_s, thr_s[sec]));
    e.rd_n = 32'(rd_model(s, fm_n, gm_n, thr_n));
    e.ex_s = (act < ms) ? act : ms;
    e.ex_n = (act < mn) ? act : mn;
    e.tag = tag;
    sb.push_back(e);
    thr_s[sec] = thr_next(s, int'(we), int'(d), thr_s[sec]);
    thr_n = thr_next(s, int'(we), int'(d), thr_n);
    if (we && s == 16) begin gm_s = int'(d[0]); gm_n = int'(d[0]); end
    if (we && s == 19) begin fm_s = int'(d[0]); fm_n = int'(d[0]); end
  endtask

  // monitor: pops one expected item per clock after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "rd_data(sec)", int'(rd_s), int'(e.rd_s));
        check(e.tag, "rd_data(nosec)", int'(rd_n), int'(e.rd_n));
        check(e.tag, "exec_prio(sec)", int'(ex_s), e.ex_s);
        check(e.tag, "exec_prio(nosec)", int'(ex_n), e.ex_n);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    thr_s[0] = 0; thr_s[1] = 0; thr_n = 0;
    gm_s = 0; fm_s = 0; gm_n = 0; fm_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs during reset
    check("R8", "rd_data in reset", int'(rd_s), 0);
    check("R8", "exec_prio in reset", int'(ex_s), 256);
    check("R8", "exec_prio nosec in reset", int'(ex_n), 256);
    rst = 1'b0;

    // R8: cleared state after reset, both banks
    op(16, 0, 0, 0, 8'hFF, 256, "R8");
    op(17, 0, 0, 0, 8'hFF, 256, "R8");
    op(17, 0, 0, 1, 8'hFF, 256, "R8");
    op(19, 0, 0, 1, 8'hFF, 256, "R8");

    // R2: low byte only; R10: same-cycle read returns old value
    op(17, 1, 32'h1234_56A0, 0, 8'hFF, 256, "R2_R10");
    op(17, 0, 0, 0, 8'hFF, 256, "R2");
    // R1 / R11: other bank untouched; non-secure-capable copy ignores sec_state
    op(17, 0, 0, 1, 8'hFF, 256, "R1_R11");
    op(17, 1, 32'h0000_0155, 1, 8'hF0, 256, "R1");
    op(17, 0, 0, 1, 8'hF0, 256, "R1");
    op(17, 0, 0, 0, 8'hF0, 256, "R1_R11");

    // R3: raise-only alias on the secure bank (starts 0x55)
    op(17, 1, 32'h0, 1, 8'hFF, 256, "R3");
    op(18, 1, 32'h80, 1, 8'hFF, 256, "R3");
    op(18, 1, 32'h90, 1, 8'hFF, 256, "R3");
    op(18, 1, 32'h60, 1, 8'hFF, 256, "R3");
    op(18, 1, 32'h00, 1, 8'hFF, 256, "R3");
    op(18, 1, 32'h160, 1, 8'hFF, 256, "R3");
    op(18, 1, 32'h20, 1, 8'hFF, 256, "R3");
    // R4: reads through both codes
    op(18, 0, 0, 1, 8'hFF, 256, "R4");
    op(17, 0, 0, 1, 8'hFF, 256, "R4");
    op(18, 0, 0, 0, 8'hFF, 256, "R4");

    // R5: mask bits keep bit 0
    op(16, 1, 32'hFFFE, 0, 8'hFF, 256, "R5");
    op(16, 0, 0, 0, 8'hFF, 256, "R5");
    op(16, 1, 32'h3, 0, 8'hFF, 256, "R5");
    op(19, 1, 32'h5, 0, 8'hFF, 256, "R5");
    op(19, 0, 0, 0, 8'hFF, 256, "R5");

    // R6: priority order with both masks set, then peel off
    op(0, 0, 0, 1, 8'hE0, 256, "R6");
    op(19, 1, 0, 1, 8'hE0, 256, "R6");
    op(0, 0, 0, 1, 8'hE0, 256, "R6");
    op(16, 1, 0, 1, 8'hE0, 256, "R6");
    op(0, 0, 0, 1, 8'hE0, 256, "R6");
    op(0, 0, 0, 0, 8'hC0, 256, "R6");
    op(17, 1, 0, 0, 8'hC0, 256, "R6");
    op(0, 0, 0, 0, 8'hC0, 256, "R6");
    op(0, 0, 0, 1, 8'h0F, 256, "R6");

    // R7: active priority below the mask wins; above it loses
    op(0, 0, 0, 1, 8'hFF, 16, "R7");
    op(0, 0, 0, 1, 8'hFF, 200, "R7");
    op(0, 0, 0, 1, 8'hFF, -1, "R7");
    op(19, 1, 1, 1, 8'hFF, 5, "R7");
    op(0, 0, 0, 1, 8'hFF, 5, "R7");
    op(19, 1, 0, 1, 8'hFF, 5, "R7");

    // R9: unsupported codes read zero and write nothing
    op(5, 1, 32'hFFFF_FFFF, 1, 8'hFF, 256, "R9");
    op(20, 1, 32'hFFFF_FFFF, 0, 8'hFF, 256, "R9");
    op(31, 1, 32'hFFFF_FFFF, 1, 8'hFF, 256, "R9");
    op(15, 1, 32'hFFFF_FFFF, 1, 8'hFF, 256, "R9");
    op(16, 0, 0, 1, 8'hFF, 256, "R9");
    op(19, 0, 0, 1, 8'hFF, 256, "R9");
    op(17, 0, 0, 1, 8'hFF, 256, "R9");
    op(17, 0, 0, 0, 8'hFF, 256, "R9");

    // R10: back-to-back writes, each read sees the prior value
    op(17, 1, 32'h11, 1, 8'hFF, 256, "R10");
    op(17, 1, 32'h22, 1, 8'hFF, 256, "R10");
    op(18, 1, 32'h10, 1, 8'hFF, 256, "R10");
    op(17, 0, 0, 1, 8'hFF, 256, "R10");

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule